// File: doc/BRIEF.md
# Sector Storage Controller Register Model

This block is a slave-side model of a removable-media storage controller as seen from a host processor. It sits on a synchronous 16-bit register bus addressed by byte offsets. Host firmware drives it the same way it would drive the real controller. The firmware first takes a single ownership lock and loads a 28-bit sector address. It then issues a read command with a sector count, and drains 512-byte sectors through a data port in handshaked groups of sixteen 16-bit words.

Sector contents come from a computed pattern memory. Each word is indexed by the current sector address and by the word position within the sector, so a checker can predict every word it reads. A card-present input and a busy-delay input let a test insert a missing card or a slow buffer fill. The model targets simulation and FPGA loopback. Media timing and the configuration engine are not modelled.

Read data is combinational from the presented address. A read strobe on the data port consumes the word shown, but only while the buffer is ready.

Top module: `cfRegModel`

## Requirements
- R1: After reset, the bus-width register (offset 0x00) reads 0, and with a card present the status register (offset 0x04) reads 0x0110, which means card detected (bit 4) and ready for command (bit 8).
- R2: Writing offset 0x00 stores only bit 0, which selects 16-bit mode when 1 and 8-bit mode when 0. The other bits read back as 0.
- R3: Control bit 1 (offset 0x18) is the lock request. Status bit 1 (lock granted) takes the value of the request one clock later, so clearing the request releases the lock. The control register reads back what was written.
- R4: The address is 28 bits. Offset 0x10 holds bits 15:0. Offset 0x12 holds bits 27:16, and its upper 4 bits are discarded and read as 0.
- R5: A write to offset 0x14 with command byte (bits 15:8) equal to 0x03 starts a read when the lock is granted, a card is present and status bit 8 is set. Status bit 8 is clear from the next clock until the command completes.
- R6: Buffer ready (status bit 5) rises exactly busyDelay+1 clocks after the starting write. It rises again exactly busyDelay+1 clocks after the last word of each group is taken.
- R7: Each ready period delivers exactly 16 words from offset 0x40. Buffer ready is clear in the clock after the 16th word is taken, and each sector takes 16 such groups.
- R8: The word at position p (0..255) of the k-th sector read is {A[7:0], p[7:0]}, where A is the loaded start address plus k, carried across all 28 bits.
- R9: A count byte (bits 7:0 of offset 0x14) of 0 transfers 256 sectors. Any other value transfers that many sectors.
- R10: A command byte other than 0x03, or any command written without the lock granted, starts nothing: status bit 8 stays set and bit 5 stays clear.
- R11: With the card absent, status bits 4 and 8 read 0 and commands are ignored. Removing the card during a read abandons the read, so buffer ready falls and no transfer resumes when the card returns.
- R12: Reading offset 0x40 while buffer ready is clear returns 0 and does not advance the word position.
- R13: Status bit 8 returns in the clock after the last word of the last sector is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 7 | Register byte offset |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 16 | Write data |
| busRdEn | input | 1 | Read strobe; consumes a data-port word when buffer ready is set |
| busRdData | output | 16 | Read data for busAddr (combinational) |
| cardPresent | input | 1 | Media inserted |
| busyDelay | input | 8 | Clocks of extra latency before each group becomes ready |

## Verification
The bench targets the group boundary. A design that miscounts there would hand out a 17th word or stall after 15, and the bench checks for both, with and without an injected busy delay. A 256-sector read from an address near the top of the 28-bit range checks both the zero-means-256 count and the carry of the sector address. A design that treated 0 as zero sectors would return to ready at once, and one that kept a narrow counter would repeat data. Further tests cover a data-port read before the buffer is ready, which must not skip word 0. They also cover commands without the lock or with a wrong opcode, which must not start a transfer, and removal of the card in the middle of a group, which must not leave buffer ready set or resume the transfer when the card returns.

// File: rtl/cfRegPkg.sv
package cfRegPkg;
  localparam int ADDR_W = 7;
  localparam int DATA_W = 16;
  localparam int COUNT_W = 8;
  localparam int MAX_SECTORS = 1 << COUNT_W;

  localparam logic [ADDR_W-1:0] OFF_MODE  = 7'h00;
  localparam logic [ADDR_W-1:0] OFF_STAT  = 7'h04;
  localparam logic [ADDR_W-1:0] OFF_LBALO = 7'h10;
  localparam logic [ADDR_W-1:0] OFF_LBAHI = 7'h12;
  localparam logic [ADDR_W-1:0] OFF_CMD   = 7'h14;
  localparam logic [ADDR_W-1:0] OFF_CTRL  = 7'h18;
  localparam logic [ADDR_W-1:0] OFF_DATA  = 7'h40;

  localparam logic [7:0] OP_READ = 8'h03;
  localparam int LOCK_BIT = 1;
  localparam int ST_LOCK = 1;
  localparam int ST_CARD = 4;
  localparam int ST_BUF  = 5;
  localparam int ST_RDY  = 8;

  typedef struct packed {
    logic launch;
    logic nextSector;
  } seqStrobe_t;
endpackage

// File: rtl/cfSeqCtrl.sv
module cfSeqCtrl
  import cfRegPkg::*;
#(
  parameter int WORDS_PER_GROUP = 16,
  parameter int GROUPS_PER_SECTOR = 16,
  parameter int BUSY_W = 8,
  localparam int SW = $clog2(WORDS_PER_GROUP * GROUPS_PER_SECTOR),
  localparam int GW = $clog2(WORDS_PER_GROUP),
  localparam int CNT_W = $clog2(MAX_SECTORS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cardPresent,
  input  logic              lockGrant,
  input  logic              cmdWrite,
  input  logic [DATA_W-1:0] cmdData,
  input  logic              popReq,
  input  logic [BUSY_W-1:0] busyDelay,
  output seqStrobe_t        strobe,
  output logic              bufReady,
  output logic              cmdReady,
  output logic [SW-1:0]     secWord
);
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_READY} seqState_t;

  seqState_t state;
  logic [BUSY_W-1:0] busyCnt;
  logic [CNT_W-1:0] sectLeft;
  logic pop, lastInGroup, lastInSector, lastSector;
  logic [CNT_W-1:0] loadCount;

  assign cmdReady = cardPresent && (state == ST_IDLE);
  assign bufReady = (state == ST_READY);
  assign pop = popReq && bufReady;
  assign lastInGroup = &secWord[GW-1:0];
  assign lastInSector = &secWord;
  assign lastSector = (sectLeft == CNT_W'(1));
  assign loadCount = (cmdData[COUNT_W-1:0] == '0) ? CNT_W'(MAX_SECTORS)
                                                   : CNT_W'(cmdData[COUNT_W-1:0]);

  always_comb begin
    strobe.launch = cmdWrite && (cmdData[DATA_W-1:COUNT_W] == OP_READ) &&
                    lockGrant && cmdReady;
    strobe.nextSector = pop && lastInSector;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      busyCnt <= '0;
      sectLeft <= '0;
      secWord <= '0;
    end else if (!cardPresent) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: if (strobe.launch) begin
          state <= ST_WAIT;
          busyCnt <= busyDelay;
          secWord <= '0;
          sectLeft <= loadCount;
        end
        ST_WAIT: begin
          if (busyCnt == '0) state <= ST_READY;
          else busyCnt <= busyCnt - 1'b1;
        end
        ST_READY: if (pop) begin
          secWord <= secWord + 1'b1;
          if (lastInSector) sectLeft <= sectLeft - 1'b1;
          if (lastInGroup) begin
            if (lastInSector && lastSector) begin
              state <= ST_IDLE;
            end else begin
              state <= ST_WAIT;
              busyCnt <= busyDelay;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfRegFile.sv
module cfRegFile
  import cfRegPkg::*;
#(
  parameter int LBA_W = 28,
  parameter int SW = 8,
  localparam int HI_W = LBA_W - 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busRdEn,
  output logic [DATA_W-1:0] busRdData,
  input  logic              cardPresent,
  input  logic              bufReady,
  input  logic              cmdReady,
  input  seqStrobe_t        strobe,
  input  logic [SW-1:0]     secWord,
  output logic              cmdWrite,
  output logic [DATA_W-1:0] cmdData,
  output logic              popReq,
  output logic              lockReq,
  output logic              lockGrant
);
  logic modeBit;
  logic [DATA_W-1:0] ctrlReg, lbaLo, cmdReg;
  logic [HI_W-1:0] lbaHi;
  logic [LBA_W-1:0] curLba;
  logic [DATA_W-1:0] statusWord;

  assign cmdWrite = busWrEn && (busAddr == OFF_CMD);
  assign cmdData = busWrData;
  assign popReq = busRdEn && (busAddr == OFF_DATA);
  assign lockReq = ctrlReg[LOCK_BIT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeBit <= 1'b0;
      ctrlReg <= '0;
      lbaLo <= '0;
      lbaHi <= '0;
      cmdReg <= '0;
      lockGrant <= 1'b0;
      curLba <= '0;
    end else begin
      if (busWrEn) begin
        case (busAddr)
          OFF_MODE:  modeBit <= busWrData[0];
          OFF_CTRL:  ctrlReg <= busWrData;
          OFF_LBALO: lbaLo <= busWrData;
          OFF_LBAHI: lbaHi <= busWrData[HI_W-1:0];
          OFF_CMD:   cmdReg <= busWrData;
          default: ;
        endcase
      end
      lockGrant <= ctrlReg[LOCK_BIT];
      if (strobe.launch) curLba <= {lbaHi, lbaLo};
      else if (strobe.nextSector) curLba <= curLba + 1'b1;
    end
  end

  always_comb begin
    statusWord = '0;
    statusWord[ST_LOCK] = lockGrant;
    statusWord[ST_CARD] = cardPresent;
    statusWord[ST_BUF] = bufReady;
    statusWord[ST_RDY] = cmdReady;
  end

  always_comb begin
    case (busAddr)
      OFF_MODE:  busRdData = {{(DATA_W-1){1'b0}}, modeBit};
      OFF_STAT:  busRdData = statusWord;
      OFF_LBALO: busRdData = lbaLo;
      OFF_LBAHI: busRdData = DATA_W'(lbaHi);
      OFF_CMD:   busRdData = cmdReg;
      OFF_CTRL:  busRdData = ctrlReg;
      OFF_DATA:  busRdData = bufReady ? DATA_W'({curLba, secWord}) : '0;
      default:   busRdData = '0;
    endcase
  end
endmodule

// File: rtl/cfRegModel.sv
module cfRegModel
  import cfRegPkg::*;
#(
  parameter int LBA_W = 28,
  parameter int WORDS_PER_GROUP = 16,
  parameter int GROUPS_PER_SECTOR = 16,
  parameter int BUSY_W = 8,
  localparam int SW = $clog2(WORDS_PER_GROUP * GROUPS_PER_SECTOR)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busRdEn,
  output logic [DATA_W-1:0] busRdData,
  input  logic              cardPresent,
  input  logic [BUSY_W-1:0] busyDelay
);
  seqStrobe_t seqStrobe;
  logic bufReady, cmdReady, cmdWrite, popReq, lockReq, lockGrant, launchPulse;
  logic [DATA_W-1:0] cmdData;
  logic [SW-1:0] secWord;

  assign launchPulse = seqStrobe.launch;

  cfSeqCtrl #(
    .WORDS_PER_GROUP(WORDS_PER_GROUP),
    .GROUPS_PER_SECTOR(GROUPS_PER_SECTOR),
    .BUSY_W(BUSY_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cardPresent(cardPresent), .lockGrant(lockGrant),
    .cmdWrite(cmdWrite), .cmdData(cmdData), .popReq(popReq), .busyDelay(busyDelay),
    .strobe(seqStrobe), .bufReady(bufReady), .cmdReady(cmdReady), .secWord(secWord)
  );

  cfRegFile #(.LBA_W(LBA_W), .SW(SW)) u_regs (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdEn(busRdEn), .busRdData(busRdData),
    .cardPresent(cardPresent), .bufReady(bufReady), .cmdReady(cmdReady),
    .strobe(seqStrobe), .secWord(secWord), .cmdWrite(cmdWrite), .cmdData(cmdData),
    .popReq(popReq), .lockReq(lockReq), .lockGrant(lockGrant)
  );
endmodule

// File: rtl/cfRegChecker.sv
module cfRegChecker (
  input logic clk,
  input logic rstN,
  input logic cardPresent,
  input logic cmdReady,
  input logic bufReady,
  input logic lockReq,
  input logic lockGrant,
  input logic launch
);
  // R3: grant takes the request value one clock later
  assert_lock_follows_R3: assert property (@(posedge clk) disable iff (!rstN)
    (lockReq != lockGrant) |=> (lockGrant == $past(lockReq)));

  // R5: a started read clears ready-for-command next clock
  assert_launch_clears_ready_R5: assert property (@(posedge clk) disable iff (!rstN)
    launch |=> !cmdReady);

  // R10: a read only starts with the lock held
  assert_launch_needs_lock_R10: assert property (@(posedge clk) disable iff (!rstN)
    launch |-> lockGrant);

  // R11: no ready-for-command without a card
  assert_no_card_not_ready_R11: assert property (@(posedge clk) disable iff (!rstN)
    !cardPresent |-> !cmdReady);

  // R11: card loss drops buffer ready
  assert_card_loss_drops_buf_R11: assert property (@(posedge clk) disable iff (!rstN)
    !cardPresent |=> !bufReady);

  // R13: buffer ready and ready-for-command never both set
  assert_ready_exclusive_R13: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({bufReady, cmdReady}));
endmodule

bind cfRegModel cfRegChecker u_chk (
  .clk(clk), .rstN(rstN), .cardPresent(cardPresent), .cmdReady(cmdReady),
  .bufReady(bufReady), .lockReq(lockReq), .lockGrant(lockGrant), .launch(launchPulse)
);

// File: tb/tb_cfRegModel.sv
`timescale 1ns/1ps
module tb_cfRegModel;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [6:0] addr = '0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic card = 1'b1;
  logic [7:0] delay = '0;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  cfRegModel dut (
    .clk(clk), .rstN(rstN), .busAddr(addr), .busWrEn(wrEn), .busWrData(wdata),
    .busRdEn(rdEn), .busRdData(rdata), .cardPresent(card), .busyDelay(delay)
  );

  task automatic check(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic busWrite(input logic [6:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRead(input logic [6:0] a, output logic [15:0] d);
    rdEn = 1'b0; addr = a;
    #1;
    d = rdata;
  endtask

  task automatic takeLock();
    busWrite(7'h18, 16'h0002);
    @(negedge clk);
  endtask

  // drains n sectors starting at lba; checks every word, the delay and the handshake
  task automatic drain(input logic [27:0] lba, input int n, input bit checkDelay, input string tag);
    int badData = 0, badDelay = 0, badHs = 0;
    logic [15:0] s;
    logic [27:0] cur;
    for (int sec = 0; sec < n; sec++) begin
      cur = lba + 28'(sec);
      for (int g = 0; g < 16; g++) begin
        int k = 0;
        busRead(7'h04, s);
        while (!s[5] && k < 2000) begin
          @(negedge clk); k++;
          busRead(7'h04, s);
        end
        if (checkDelay && k != int'(delay) + 1) badDelay++;
        if (!s[5]) badHs++;
        addr = 7'h40; rdEn = 1'b1;
        for (int w = 0; w < 16; w++) begin
          #1;
          if (rdata !== {cur[7:0], 4'(g), 4'(w)}) begin
            if (badData == 0) $display("FAIL R8 %s word %0d/%0d/%0d: actual %h expected %h",
                                       tag, sec, g, w, rdata, {cur[7:0], 4'(g), 4'(w)});
            badData++;
          end
          @(negedge clk);
        end
        rdEn = 1'b0;
        busRead(7'h04, s);
        if (s[5]) badHs++;
        if (s[8] !== ((sec == n - 1) && (g == 15))) badHs++;
      end
    end
    check("R8", {tag, " data mismatches"}, 16'(badData), 16'd0);
    if (checkDelay) check("R6", {tag, " busy delay mismatches"}, 16'(badDelay), 16'd0);
    check("R7", {tag, " group handshake errors"}, 16'(badHs), 16'd0);
    busRead(7'h04, s);
    check("R13", {tag, " ready after last word"}, 16'(s[8]), 16'd1);
  endtask

  task automatic testReset();
    logic [15:0] d;
    busRead(7'h00, d); check("R1", "mode after reset", d, 16'h0000);
    busRead(7'h04, d); check("R1", "status after reset", d, 16'h0110);
  endtask

  task automatic testMode();
    logic [15:0] d;
    busWrite(7'h00, 16'hFFFF);
    busRead(7'h00, d); check("R2", "mode set", d, 16'h0001);
    busWrite(7'h00, 16'hFFFE);
    busRead(7'h00, d); check("R2", "mode clear", d, 16'h0000);
  endtask

  task automatic testLock();
    logic [15:0] d;
    busWrite(7'h18, 16'h0002);
    busRead(7'h18, d); check("R3", "control readback", d, 16'h0002);
    @(negedge clk);
    busRead(7'h04, d); check("R3", "lock granted", d, 16'h0112);
    busWrite(7'h18, 16'h0000);
    @(negedge clk);
    busRead(7'h04, d); check("R3", "lock released", d, 16'h0110);
  endtask

  task automatic testLba();
    logic [15:0] d;
    busWrite(7'h12, 16'hFABC);
    busRead(7'h12, d); check("R4", "high address upper bits dropped", d, 16'h0ABC);
    busWrite(7'h10, 16'h1234);
    busRead(7'h10, d); check("R4", "low address", d, 16'h1234);
  endtask

  task automatic testReject();
    logic [15:0] d;
    busWrite(7'h14, 16'h0301);
    repeat (3) @(negedge clk);
    busRead(7'h04, d); check("R10", "command without lock", d, 16'h0110);
    takeLock();
    busWrite(7'h14, 16'h0201);
    repeat (3) @(negedge clk);
    busRead(7'h04, d); check("R10", "wrong opcode", d, 16'h0112);
    busRead(7'h14, d); check("R10", "command readback", d, 16'h0201);
  endtask

  task automatic testRead(input logic [27:0] lba, input logic [7:0] cnt, input logic [7:0] dly, input string tag);
    logic [15:0] d;
    int n;
    n = (cnt == 0) ? 256 : int'(cnt);
    delay = dly;
    busWrite(7'h10, lba[15:0]);
    busWrite(7'h12, {4'h0, lba[27:16]});
    busWrite(7'h14, {8'h03, cnt});
    busRead(7'h04, d); check("R5", {tag, " ready cleared"}, 16'(d[8]), 16'd0);
    drain(lba, n, 1'b1, tag);
  endtask

  task automatic testEarlyPop();
    logic [15:0] d;
    delay = 8'd6;
    busWrite(7'h10, 16'h0077);
    busWrite(7'h12, 16'h0000);
    busWrite(7'h14, 16'h0301);
    addr = 7'h40; rdEn = 1'b1;
    #1; d = rdata;
    check("R12", "data before buffer ready", d, 16'h0000);
    @(negedge clk);
    rdEn = 1'b0;
    drain(28'h77, 1, 1'b0, "early-pop");
  endtask

  task automatic testCard();
    logic [15:0] d;
    int k;
    card = 1'b0;
    @(negedge clk);
    busRead(7'h04, d); check("R11", "status without card", d, 16'h0002);
    busWrite(7'h14, 16'h0301);
    @(negedge clk);
    card = 1'b1;
    repeat (3) @(negedge clk);
    busRead(7'h04, d); check("R11", "command ignored without card", d, 16'h0112);
    delay = 8'd2;
    busWrite(7'h14, 16'h0302);
    k = 0;
    busRead(7'h04, d);
    while (!d[5] && k < 100) begin @(negedge clk); k++; busRead(7'h04, d); end
    addr = 7'h40; rdEn = 1'b1;
    repeat (3) @(negedge clk);
    rdEn = 1'b0;
    card = 1'b0;
    @(negedge clk);
    busRead(7'h04, d); check("R11", "removal mid-read", d, 16'h0002);
    card = 1'b1;
    repeat (10) @(negedge clk);
    busRead(7'h04, d); check("R11", "no resume after reinsertion", d, 16'h0112);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", checks + 1, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testMode();
    testLock();
    testLba();
    testReject();
    testRead(28'h00000A5, 8'd2, 8'd3, "two-sector");
    testRead(28'h0000300, 8'd1, 8'd0, "no-delay");
    testEarlyPop();
    testRead(28'hFFFFFF0, 8'd0, 8'd0, "count-zero R9");
    testCard();
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule